// File: doc/BRIEF.md
# Demote-Only Region Cache-Mode Register

This block keeps one cache mode for each of sixteen memory regions and answers, without a clock delay, which mode applies to a given address. The region is picked by the four most significant address bits. Out of reset every region sits in its highest mode, write-back. Software can only lower a region's mode. It does so by presenting a one-cycle demote request that carries a region index and the new mode. One cycle later the block reports whether the request was granted or denied. Nothing except reset raises a mode again.

The request index is reversed with respect to the region number. Index 0 addresses region 15, and index 15 addresses region 0. The lookup path does not reverse the region number. A small response state machine has three states. It is in `ST_IDLE` when no request was seen on the previous edge, in `ST_GRANT` after a legal demote, and in `ST_DENY` after a rejected request. On each clock edge the transition goes to `ST_GRANT` when a request is present and legal, to `ST_DENY` when a request is present and illegal, and to `ST_IDLE` when no request is present. This choice does not depend on the current state. Every state returns to `ST_IDLE` when no request follows.

Top module: `rmode_ctrl`

## Requirements
- R1: After reset every region reads mode 3 (write-back), and `rsp_valid` is 0.
- R2: Mode codes are 0 = non-cacheable, 2 = write-through, 3 = write-back. `lookup_mode` gives the mode of the region numbered by `lookup_addr[31:28]`. The lower 28 address bits have no effect.
- R3: A request with `req_index` = i acts on region 15 - i.
- R4: A request whose mode is 0 or 2 and strictly below the target's current mode is granted. It returns `rsp_valid`=1 and `rsp_ok`=1 in the next cycle. From that same next cycle the lookup shows the new mode.
- R5: A request whose mode is greater than or equal to the target's current mode is denied. It returns `rsp_valid`=1 and `rsp_ok`=0 in the next cycle, and the stored mode is unchanged.
- R6: A request carrying code 1 is denied and changes no region.
- R7: `rsp_valid` is 1 exactly in the cycle after each request and 0 otherwise. `rsp_ok` is 0 whenever `rsp_valid` is 0.
- R8: No region's mode ever increases except through reset. A reset after demotions restores mode 3 everywhere.
- R9: A request never alters any region other than its target.
- R10: In the cycle a request is presented, a lookup of its target region still shows the mode from before the request. Back-to-back requests to one region are judged against the mode left by the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, restores write-back everywhere |
| req_valid | input | 1 | Demote request present this cycle |
| req_index | input | 4 | Request index, reversed: index i targets region 15 - i |
| req_mode | input | 2 | Requested new mode |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_ok | output | 1 | 1 = granted, 0 = denied |
| lookup_addr | input | 32 | Address to classify |
| lookup_mode | output | 2 | Mode of the region that the address selects |

## Verification
Lookup and demotion can meet in the same cycle. The bench points `lookup_addr` at the very region a request is demoting, while the request is on the port. It judges the combinational lookup against the mode held by its model from before the request. One cycle later it judges the lookup against the updated model value. Pairs of requests to one region with no gap show that the second judgement uses the mode the first request left behind.

// File: rtl/rmode_pkg.sv
package rmode_pkg;
    localparam logic [1:0] MODE_UNCACHED = 2'd0;
    localparam logic [1:0] MODE_RSVD     = 2'd1;
    localparam logic [1:0] MODE_THROUGH  = 2'd2;
    localparam logic [1:0] MODE_BACK     = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_DENY  = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/rmode_store.sv
module rmode_store
    import rmode_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int MODE_W = 2,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_region,
    input  logic [MODE_W-1:0]        wr_mode,
    output logic [NREG*MODE_W-1:0]   modes_flat
);
    logic [MODE_W-1:0] mode_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_region
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[g] <= MODE_W'(MODE_BACK);
            end else if (wr_en && (wr_region == IDX_W'(g))) begin
                mode_q[g] <= wr_mode;
            end
        end
        assign modes_flat[g*MODE_W +: MODE_W] = mode_q[g];

        // R8: a stored mode only ever moves down while out of reset
        assert_mode_never_rises_R8: assert property (@(posedge clk) disable iff (!rst_n)
            mode_q[g] <= $past(mode_q[g]));
        // R6: the reserved code never lands in storage
        assert_no_reserved_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
            mode_q[g] != MODE_W'(MODE_RSVD));
    end
endmodule

// File: rtl/rmode_pick.sv
module rmode_pick #(
    parameter int NREG   = 16,
    parameter int MODE_W = 2,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [NREG*MODE_W-1:0] modes_flat,
    input  logic [IDX_W-1:0]       sel,
    output logic [MODE_W-1:0]      mode
);
    always_comb begin
        mode = '0;
        for (int k = 0; k < NREG; k++) begin
            if (sel == IDX_W'(k)) begin
                mode = modes_flat[k*MODE_W +: MODE_W];
            end
        end
    end
endmodule

// File: rtl/rmode_judge.sv
module rmode_judge
    import rmode_pkg::*;
#(
    parameter int MODE_W = 2
) (
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [MODE_W-1:0] req_mode,
    output logic              grant
);
    always_comb begin
        grant = (req_mode != MODE_W'(MODE_RSVD)) && (req_mode < cur_mode);
    end
endmodule

// File: rtl/rmode_resp_fsm.sv
module rmode_resp_fsm
    import rmode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic grant,
    output logic rsp_valid,
    output logic rsp_ok
);
    rsp_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            state_d = grant ? ST_GRANT : ST_DENY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_ok    = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin rsp_valid = 1'b0; rsp_ok = 1'b0; end
            ST_GRANT: begin rsp_valid = 1'b1; rsp_ok = 1'b1; end
            ST_DENY:  begin rsp_valid = 1'b1; rsp_ok = 1'b0; end
            default:  begin rsp_valid = 1'b0; rsp_ok = 1'b0; end
        endcase
    end

    // R7: a response appears exactly one cycle after each request
    assert_rsp_after_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_ok_implies_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> rsp_valid);
endmodule

// File: rtl/rmode_ctrl.sv
module rmode_ctrl
    import rmode_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int MODE_W = 2,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [MODE_W-1:0] req_mode,
    output logic              rsp_valid,
    output logic              rsp_ok,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic [MODE_W-1:0] lookup_mode
);
    logic [NREG*MODE_W-1:0] modes_flat;
    logic [IDX_W-1:0]       target_region;
    logic [IDX_W-1:0]       lookup_region;
    logic [MODE_W-1:0]      target_mode;
    logic                   grant;

    // request index counts regions from the top down
    assign target_region = IDX_W'(NREG - 1) - req_index;
    assign lookup_region = lookup_addr[ADDR_W-1 -: IDX_W];

    rmode_pick #(.NREG(NREG), .MODE_W(MODE_W)) u_pick_target (
        .modes_flat (modes_flat),
        .sel        (target_region),
        .mode       (target_mode)
    );

    rmode_pick #(.NREG(NREG), .MODE_W(MODE_W)) u_pick_lookup (
        .modes_flat (modes_flat),
        .sel        (lookup_region),
        .mode       (lookup_mode)
    );

    rmode_judge #(.MODE_W(MODE_W)) u_judge (
        .cur_mode (target_mode),
        .req_mode (req_mode),
        .grant    (grant)
    );

    rmode_store #(.NREG(NREG), .MODE_W(MODE_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (req_valid && grant),
        .wr_region  (target_region),
        .wr_mode    (req_mode),
        .modes_flat (modes_flat)
    );

    rmode_resp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .grant     (grant),
        .rsp_valid (rsp_valid),
        .rsp_ok    (rsp_ok)
    );

    // R5: equal or higher request yields a denial next cycle
    assert_deny_not_lower_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_mode >= target_mode)) |=> (rsp_valid && !rsp_ok));
    // R6: reserved code yields a denial next cycle
    assert_deny_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_mode == MODE_W'(MODE_RSVD))) |=> (rsp_valid && !rsp_ok));
    // R4: a grant always means the stored mode went strictly down
    assert_grant_lowers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_mode < target_mode) && (req_mode != MODE_W'(MODE_RSVD)))
        |=> rsp_ok);
endmodule

// File: tb/rmode_ctrl_tb.sv
module rmode_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_index = '0;
    logic [1:0]  req_mode = '0;
    logic        rsp_valid, rsp_ok;
    logic [31:0] lookup_addr = '0;
    logic [1:0]  lookup_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int exp_mode [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    rmode_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_index   (req_index),
        .req_mode    (req_mode),
        .rsp_valid   (rsp_valid),
        .rsp_ok      (rsp_ok),
        .lookup_addr (lookup_addr),
        .lookup_mode (lookup_mode)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2: drive every region's address (low bits scrambled) and compare to the model
    task automatic sweep_lookup(input string req);
        for (int r = 0; r < 16; r++) begin
            lookup_addr = {r[3:0], 28'h5A3C96E ^ {r[3:0], 24'h0}};
            #1;
            check(lookup_mode == exp_mode[r][1:0], req, lookup_mode, exp_mode[r]);
        end
    endtask

    function automatic bit legal(input int cur, input int m);
        return (m != 1) && (m < cur);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 16; r++) exp_mode[r] = 3;
        #1;
        check(rsp_valid == 1'b0, "R1 rsp idle", rsp_valid, 0);
        sweep_lookup("R1 reset mode");
    endtask

    // single request with an idle cycle after it
    task automatic do_req(input int idx, input int m);
        int tgt;
        bit ok;
        tgt = 15 - idx;
        ok = legal(exp_mode[tgt], m);
        @(negedge clk);
        req_valid = 1'b1; req_index = idx[3:0]; req_mode = m[1:0];
        lookup_addr = {tgt[3:0], 28'h0000FFF};
        #1;
        check(lookup_mode == exp_mode[tgt][1:0], "R10 same-cycle lookup", lookup_mode, exp_mode[tgt]);
        check(rsp_valid == 1'b0, "R7 no early rsp", rsp_valid, 0);
        @(negedge clk);
        req_valid = 1'b0;
        if (ok) exp_mode[tgt] = m;
        #1;
        check(rsp_valid == 1'b1, "R7 rsp valid", rsp_valid, 1);
        if (m == 1)      check(rsp_ok == 1'b0, "R6 reserved denied", rsp_ok, 0);
        else if (ok)     check(rsp_ok == 1'b1, "R4 grant", rsp_ok, 1);
        else             check(rsp_ok == 1'b0, "R5 deny", rsp_ok, 0);
        sweep_lookup("R3 R9 region state");
        @(negedge clk);
        #1;
        check(rsp_valid == 1'b0 && rsp_ok == 1'b0, "R7 rsp drop", rsp_valid, 0);
    endtask

    // two requests to the same index with no gap (R10)
    task automatic do_pair(input int idx, input int m1, input int m2);
        int tgt;
        bit ok1, ok2;
        tgt = 15 - idx;
        @(negedge clk);
        req_valid = 1'b1; req_index = idx[3:0]; req_mode = m1[1:0];
        ok1 = legal(exp_mode[tgt], m1);
        if (ok1) exp_mode[tgt] = m1;
        @(negedge clk);
        req_mode = m2[1:0];
        ok2 = legal(exp_mode[tgt], m2);
        #1;
        check(rsp_ok == ok1, "R10 pair first", rsp_ok, ok1);
        @(negedge clk);
        req_valid = 1'b0;
        if (ok2) exp_mode[tgt] = m2;
        #1;
        check(rsp_valid == 1'b1 && rsp_ok == ok2, "R10 pair second", rsp_ok, ok2);
        sweep_lookup("R10 pair state");
    endtask

    initial begin
        do_reset();
        // near-exhaustive: every index sees a rotating mix of all four codes
        for (int i = 0; i < 16; i++) begin
            for (int s = 0; s < 8; s++) begin
                do_req(i, (i + s) % 4);
            end
        end
        // R8: all regions demoted somewhere; a raise attempt must fail
        do_req(3, 3);
        do_reset();
        do_req(0, 1);
        do_req(0, 3);
        do_req(0, 0);
        do_req(0, 2);
        do_pair(5, 2, 0);
        do_pair(6, 0, 2);
        do_pair(7, 2, 2);
        do_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule